// File: doc/BRIEF.md
# AES Single-Round Datapath

This unit carries out one AES round on a 128-bit state per lane, with the 128-bit round key supplied from outside. An outer sequencer, either software or a controller, issues one request per round. It feeds back the state the unit returned, and it supplies the next round key each time. Key expansion and chaining across blocks stay outside the unit.

A two-bit operation code picks the round flavour:

- an encrypt round or a decrypt round;
- each of them as a middle round or as a final round, where the final round drops the column mixing step.

Several lanes run side by side. Each lane takes its own key, or every lane uses the key of lane 0. A per-lane enable lets a disabled lane return its input state untouched. The result is registered, and it stands in place of the input state, so no separate destination exists.

Top module: `aes_round_unit`

## Requirements
- R1: While reset is low, and on the first cycle after it, `state_out` is all zeros and `out_done` is 0.
- R2: `out_done` is 1 in exactly the cycle after a cycle in which `in_valid` was 1, and is 0 otherwise.
- R3: With `op_sel` = 2'b00 (encrypt middle round), an enabled lane returns MixColumns(ShiftRows(SubBytes(state))) XOR key.
- R4: With `op_sel` = 2'b01 (encrypt final round), an enabled lane returns ShiftRows(SubBytes(state)) XOR key.
- R5: With `op_sel` = 2'b10 (decrypt middle round), an enabled lane returns InvMixColumns(InvSubBytes(InvShiftRows(state)) XOR key).
- R6: With `op_sel` = 2'b11 (decrypt final round), an enabled lane returns InvSubBytes(InvShiftRows(state)) XOR key.
- R7: Within a lane, byte k of the state sits in bits [127-8k -: 8], and the bytes fill the columns in turn: byte k is row k mod 4 of column k div 4. Lane g occupies bits [128g +: 128] of `state_in`, `key_in` and `state_out`.
- R8: When `lane_en[g]` is 0 during a request, lane g of `state_out` equals lane g of `state_in` from that request.
- R9: When `key_shared` is 1, every lane uses lane 0 of `key_in`, and the other lanes of `key_in` have no effect on the result.
- R10: In a cycle without `in_valid`, `state_out` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request strobe; loads the operands and starts a round |
| op_sel | input | 2 | Bit 1: decrypt; bit 0: final round |
| key_shared | input | 1 | 1: all lanes use the key of lane 0 |
| lane_en | input | LANES | Per-lane enable; a 0 passes that lane's state through |
| state_in | input | 128*LANES | Input states, lane g at [128g +: 128] |
| key_in | input | 128*LANES | Round keys, lane g at [128g +: 128] |
| state_out | output | 128*LANES | Registered round result |
| out_done | output | 1 | One-cycle pulse when a result is available |

## Verification
Every result, whether a computed round, a passed-through lane or a shared-key lane, appears on `state_out` one clock after the edge that samples `in_valid`, together with `out_done`. The bench drives operands on a falling edge and holds them over one rising edge. It checks `state_out` and `out_done` at the next falling edge, and one falling edge later it checks that `out_done` has dropped and that `state_out` has not moved. Expected round results come from published intermediate values of the cipher, combined by XOR with the chosen keys.

// File: rtl/aes_round_unit.sv
module aes_round_unit #(
  parameter int LANES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [1:0]           op_sel,
  input  logic                 key_shared,
  input  logic [LANES-1:0]     lane_en,
  input  logic [LANES*128-1:0] state_in,
  input  logic [LANES*128-1:0] key_in,
  output logic [LANES*128-1:0] state_out,
  output logic                 out_done
);

  localparam int W = LANES * 128;

  function automatic logic [7:0] xt(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gm(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r, p;
    r = 8'h00;
    p = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) r = r ^ p;
      p = xt(p);
    end
    return r;
  endfunction

  function automatic logic [7:0] ginv(input logic [7:0] x);
    logic [7:0] r, p;
    r = 8'h01;
    p = x;
    for (int i = 0; i < 7; i++) begin
      p = gm(p, p);
      r = gm(r, p);
    end
    return (x == 8'h00) ? 8'h00 : r;
  endfunction

  function automatic logic [7:0] rl(input logic [7:0] b, input int n);
    logic [15:0] t;
    t = {b, b} << n;
    return t[15:8];
  endfunction

  function automatic logic [7:0] sb(input logic [7:0] x);
    logic [7:0] i;
    i = ginv(x);
    return i ^ rl(i, 1) ^ rl(i, 2) ^ rl(i, 3) ^ rl(i, 4) ^ 8'h63;
  endfunction

  function automatic logic [7:0] isb(input logic [7:0] x);
    return ginv(rl(x, 1) ^ rl(x, 3) ^ rl(x, 6) ^ 8'h05);
  endfunction

  function automatic logic [7:0] bget(input logic [127:0] s, input int k);
    return s[127-8*k -: 8];
  endfunction

  function automatic logic [127:0] sub_all(input logic [127:0] s, input logic inv);
    logic [127:0] o;
    for (int k = 0; k < 16; k++)
      o[127-8*k -: 8] = inv ? isb(bget(s, k)) : sb(bget(s, k));
    return o;
  endfunction

  function automatic logic [127:0] shift(input logic [127:0] s, input logic inv);
    logic [127:0] o;
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++)
        o[127-8*(4*c+r) -: 8] = inv ? bget(s, 4*((c + 4 - r) % 4) + r)
                                    : bget(s, 4*((c + r) % 4) + r);
    return o;
  endfunction

  function automatic logic [127:0] mix(input logic [127:0] s, input logic inv);
    logic [127:0] o;
    logic [7:0] a0, a1, a2, a3;
    for (int c = 0; c < 4; c++) begin
      a0 = bget(s, 4*c);
      a1 = bget(s, 4*c+1);
      a2 = bget(s, 4*c+2);
      a3 = bget(s, 4*c+3);
      if (inv) begin
        o[127-8*(4*c)   -: 8] = gm(a0,8'h0e) ^ gm(a1,8'h0b) ^ gm(a2,8'h0d) ^ gm(a3,8'h09);
        o[127-8*(4*c+1) -: 8] = gm(a0,8'h09) ^ gm(a1,8'h0e) ^ gm(a2,8'h0b) ^ gm(a3,8'h0d);
        o[127-8*(4*c+2) -: 8] = gm(a0,8'h0d) ^ gm(a1,8'h09) ^ gm(a2,8'h0e) ^ gm(a3,8'h0b);
        o[127-8*(4*c+3) -: 8] = gm(a0,8'h0b) ^ gm(a1,8'h0d) ^ gm(a2,8'h09) ^ gm(a3,8'h0e);
      end else begin
        o[127-8*(4*c)   -: 8] = xt(a0) ^ xt(a1) ^ a1 ^ a2 ^ a3;
        o[127-8*(4*c+1) -: 8] = a0 ^ xt(a1) ^ xt(a2) ^ a2 ^ a3;
        o[127-8*(4*c+2) -: 8] = a0 ^ a1 ^ xt(a2) ^ xt(a3) ^ a3;
        o[127-8*(4*c+3) -: 8] = xt(a0) ^ a0 ^ a1 ^ a2 ^ xt(a3);
      end
    end
    return o;
  endfunction

  logic [W-1:0] nxt;
  logic         dec, fin;

  assign dec = op_sel[1];
  assign fin = op_sel[0];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [127:0] st, ky, enc_r, dec_r, res;

    assign st = state_in[g*128 +: 128];
    assign ky = key_shared ? key_in[127:0] : key_in[g*128 +: 128];

    always_comb begin
      enc_r = shift(sub_all(st, 1'b0), 1'b0);
      if (!fin) enc_r = mix(enc_r, 1'b0);
      enc_r = enc_r ^ ky;
      dec_r = sub_all(shift(st, 1'b1), 1'b1) ^ ky;
      if (!fin) dec_r = mix(dec_r, 1'b1);
    end

    assign res = dec ? dec_r : enc_r;
    assign nxt[g*128 +: 128] = lane_en[g] ? res : st;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_out <= '0;
      out_done  <= 1'b0;
    end else begin
      out_done <= in_valid;
      if (in_valid) state_out <= nxt;
    end
  end

endmodule

// File: rtl/aes_round_unit_chk.sv
module aes_round_unit_chk #(
  parameter int LANES = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 key_shared,
  input logic [LANES-1:0]     lane_en,
  input logic [LANES*128-1:0] state_in,
  input logic [LANES*128-1:0] state_out,
  input logic                 out_done
);

  p_done_after_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_done);

  p_no_spurious_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_done);

  p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(state_out));

  for (genvar g = 0; g < LANES; g++) begin : g_chk
    p_masked_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !lane_en[g]) |=>
        state_out[g*128 +: 128] == $past(state_in[g*128 +: 128]));

    if (g > 0) begin : g_sh
      p_shared_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && key_shared && lane_en[g] && lane_en[0] &&
         state_in[g*128 +: 128] == state_in[127:0]) |=>
          state_out[g*128 +: 128] == state_out[127:0]);
    end
  end

endmodule

bind aes_round_unit aes_round_unit_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .key_shared(key_shared),
  .lane_en(lane_en), .state_in(state_in), .state_out(state_out),
  .out_done(out_done)
);

// File: tb/sim_aes_round_unit.sv
module sim_aes_round_unit;
  localparam int LANES = 2;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 in_valid = 1'b0;
  logic [1:0]           op_sel = 2'b00;
  logic                 key_shared = 1'b0;
  logic [LANES-1:0]     lane_en = '1;
  logic [LANES*128-1:0] state_in = '0;
  logic [LANES*128-1:0] key_in = '0;
  logic [LANES*128-1:0] state_out;
  logic                 out_done;

  always #5 clk = ~clk;

  aes_round_unit #(.LANES(LANES)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
    .key_shared(key_shared), .lane_en(lane_en), .state_in(state_in),
    .key_in(key_in), .state_out(state_out), .out_done(out_done)
  );

  localparam logic [127:0] S0 = 128'h193de3bea0f4e22b9ac68d2ae9f84808;
  localparam logic [127:0] SR = 128'hd4bf5d30e0b452aeb84111f11e2798e5;
  localparam logic [127:0] MC = 128'h046681e5e0cb199a48f8d37a2806264c;
  localparam logic [127:0] KA = 128'ha0fafe1788542cb123a339392a6c7605;
  localparam logic [127:0] KB = 128'h0123456789abcdeffedcba9876543210;

  localparam int NV = 7;
  localparam logic [1:0]   V_OP [NV] = '{2'b00, 2'b00, 2'b01, 2'b01, 2'b11, 2'b11, 2'b10};
  localparam logic [127:0] V_ST [NV] = '{S0, S0, S0, S0, SR, SR, SR};
  localparam logic [127:0] V_KY [NV] = '{'0, KA, '0, KA, '0, KA, S0 ^ MC};
  localparam logic [127:0] V_EX [NV] = '{MC, MC ^ KA, SR, SR ^ KA, S0, S0 ^ KA, SR};

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic string op_tag(input logic [1:0] op);
    case (op)
      2'b00:   return "R3 enc-mid";
      2'b01:   return "R4 enc-final";
      2'b10:   return "R5 dec-mid";
      default: return "R6 dec-final";
    endcase
  endfunction

  task automatic issue(input logic [1:0] op, input logic sh, input logic [LANES-1:0] en,
                       input logic [LANES*128-1:0] st, input logic [LANES*128-1:0] ky);
    @(negedge clk);
    op_sel = op; key_shared = sh; lane_en = en; state_in = st; key_in = ky;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    logic [127:0] keep;
    repeat (3) @(negedge clk);
    chk("R1 state in reset", state_out[127:0], '0);
    chk("R1 done in reset", {127'd0, out_done}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 state after reset", state_out[255:128], '0);
    chk("R1 done after reset", {127'd0, out_done}, '0);

    for (int i = 0; i < NV; i++) begin
      issue(V_OP[i], 1'b0, 2'b11, {128'd0, V_ST[i]}, {128'd0, V_KY[i]});
      chk({op_tag(V_OP[i]), " R7 lane0"}, state_out[127:0], V_EX[i]);
      chk({op_tag(V_OP[i]), " R7 lane1 zero"}, state_out[255:128],
          V_OP[i][1] ? {16{8'h52}} : {16{8'h63}});
      chk("R2 done pulse", {127'd0, out_done}, 128'd1);
      @(negedge clk);
      chk("R2 done drops", {127'd0, out_done}, '0);
      chk("R10 idle hold", state_out[127:0], V_EX[i]);
    end

    issue(2'b01, 1'b0, 2'b01, {S0, S0}, {KA, KA});
    chk("R8 masked lane1", state_out[255:128], S0);
    chk("R8 enabled lane0", state_out[127:0], SR ^ KA);

    issue(2'b00, 1'b0, 2'b00, {KB, SR}, {KA, KA});
    chk("R8 all masked lane0", state_out[127:0], SR);
    chk("R8 all masked lane1", state_out[255:128], KB);

    issue(2'b01, 1'b1, 2'b11, {S0, S0}, {KB, KA});
    chk("R9 shared lane1", state_out[255:128], SR ^ KA);
    chk("R9 shared lane0", state_out[127:0], SR ^ KA);

    issue(2'b11, 1'b0, 2'b11, {SR, SR}, {KB, KA});
    chk("R9 per-lane key lane1", state_out[255:128], S0 ^ KB);
    keep = state_out[255:128];

    repeat (4) @(negedge clk);
    chk("R10 long idle", state_out[255:128], keep);
    chk("R2 no done idle", {127'd0, out_done}, '0);

    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 re-reset", state_out[127:0], '0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule